// File: doc/BRIEF.md
# Ramp Test Pattern Generator

This block sits in a camera video path just ahead of the output formatter. It either forwards the live 12-bit sensor pixel or replaces it with a synthetic ramp. The ramp lets an acquisition system check its link before any image tuning is done. The pattern needs no gain or offset stage, because that correction never applies to it. Any later reduction of the pixel to 10 or 8 bits happens downstream of this block.

A static 2-bit mode input selects one of three behaviours: plain video, a fixed ramp that repeats on every line, or a sliding ramp. In the sliding ramp, the first code of every line moves up by two on each new frame. The frame, line and pixel strobes pass through one register stage, so they stay aligned with the pixel word.

Top module: `ramp_pattern_gen`

## Requirements
- R1: With mode 2'b00 or 2'b11, `pix_o` equals the `pix_i` value of the previous cycle.
- R2: With mode 2'b01 or 2'b10, the k-th pixel-valid sample of a line gives (960 + frame offset + k) mod 4096 one cycle later. Samples are counted from k = 0, starting at the cycle where `lval_i` rises. In the fixed mode, sample k = 1048 therefore gives 2008.
- R3: In mode 2'b01 (fixed ramp), every line of every frame starts at 960 and carries the same ramp.
- R4: In mode 2'b10 (sliding ramp), the first frame after entering the mode uses offset 0. Each later rising edge of `fval_i` adds 2 to the offset, starting with the line that opens at that edge.
- R5: Whenever the mode is not 2'b10, the offset is cleared. Re-entering mode 2'b10 therefore restarts the first frame at 960.
- R6: `fval_o`, `lval_o` and `pval_o` equal `fval_i`, `lval_i` and `pval_i` delayed by exactly one cycle.
- R7: While `rst_n` is low, and on the first cycle after it is released, all outputs are zero.
- R8: Within a line, the sample index advances only on cycles where `pval_i` is high. Gaps in `pval_i` do not skip ramp codes.
- R9: Pattern codes wrap modulo 4096. The code that follows 4095 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 video, 01 fixed ramp, 10 sliding ramp, 11 video |
| fval_i | input | 1 | Frame-valid strobe |
| lval_i | input | 1 | Line-valid strobe |
| pval_i | input | 1 | Pixel-valid strobe |
| pix_i | input | 12 | Live sensor pixel |
| fval_o | output | 1 | Delayed frame-valid |
| lval_o | output | 1 | Delayed line-valid |
| pval_o | output | 1 | Delayed pixel-valid |
| pix_o | output | 12 | Selected pixel word |

## Verification
Every result of this block appears exactly one cycle after the inputs that cause it. This holds for the passed-through pixel, the ramp code and all three strobes. The offset bump for a new frame shows on the first line of that frame, in the same one-cycle slot.

The bench drives its inputs on the falling edge and queues the expected word for that cycle. The monitor then pops and compares that word 1 ns after the next rising edge, so each comparison lands on the one register stage. Extra end-of-line checks sample the last valid word of a full line and the wrap past 4095.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  localparam int PIX_W = 12;

  typedef enum logic [1:0] {
    MODE_VIDEO = 2'b00,
    MODE_FIXED = 2'b01,
    MODE_SLIDE = 2'b10,
    MODE_ALT   = 2'b11
  } rpg_mode_e;

  function automatic logic mode_is_test(input logic [1:0] m);
    return (m == MODE_FIXED) || (m == MODE_SLIDE);
  endfunction

  function automatic logic mode_is_slide(input logic [1:0] m);
    return m == MODE_SLIDE;
  endfunction

  // ramp code: base + offset + index, modulo 2**PIX_W
  function automatic logic [PIX_W-1:0] ramp_code(input logic [PIX_W-1:0] base,
                                                 input logic [PIX_W-1:0] off,
                                                 input logic [PIX_W-1:0] idx);
    return base + off + idx;
  endfunction
endpackage

// File: rtl/rpg_edge_detect.sv
module rpg_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/rpg_pixel_counter.sv
module rpg_pixel_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start_i,
  input  logic             lval_i,
  input  logic             pval_i,
  output logic [CNT_W-1:0] idx_o
);
  logic [CNT_W-1:0] cnt_q;

  // index of the sample presented this cycle
  assign idx_o = line_start_i ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (line_start_i)     cnt_q <= pval_i ? CNT_W'(1) : '0;
    else if (lval_i && pval_i) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/rpg_frame_offset.sv
module rpg_frame_offset #(
  parameter int OFF_W = 12,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slide_en_i,
  input  logic             frame_start_i,
  output logic [OFF_W-1:0] off_o,
  output logic             armed_o
);
  logic [OFF_W-1:0] off_q;
  logic             armed_q;
  logic             bump;

  // the first frame after entry only arms; later frames step
  assign bump    = slide_en_i && frame_start_i && armed_q;
  assign off_o   = !slide_en_i ? '0 : (bump ? off_q + OFF_W'(STEP) : off_q);
  assign armed_o = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      off_q   <= off_o;
      armed_q <= slide_en_i && (armed_q || frame_start_i);
    end
  end
endmodule

// File: rtl/ramp_pattern_gen.sv
module ramp_pattern_gen
  import rpg_pkg::*;
#(
  parameter int RAMP_BASE  = 960,
  parameter int SLIDE_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             fval_i,
  input  logic             lval_i,
  input  logic             pval_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             fval_o,
  output logic             lval_o,
  output logic             pval_o,
  output logic [PIX_W-1:0] pix_o
);
  localparam logic [PIX_W-1:0] BASE = PIX_W'(RAMP_BASE);

  // named internal events, observed by the checker
  logic             line_start;
  logic             frame_start;
  logic [PIX_W-1:0] pix_idx;
  logic [PIX_W-1:0] frame_off;
  logic             slide_armed;
  logic             test_en;
  logic             slide_en;
  logic [PIX_W-1:0] pattern;

  assign test_en  = mode_is_test(mode_i);
  assign slide_en = mode_is_slide(mode_i);

  rpg_edge_detect u_line_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(lval_i), .rise_o(line_start)
  );

  rpg_edge_detect u_frame_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(fval_i), .rise_o(frame_start)
  );

  rpg_pixel_counter #(.CNT_W(PIX_W)) u_pix_cnt (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start),
    .lval_i(lval_i), .pval_i(pval_i), .idx_o(pix_idx)
  );

  rpg_frame_offset #(.OFF_W(PIX_W), .STEP(SLIDE_STEP)) u_frame_off (
    .clk(clk), .rst_n(rst_n), .slide_en_i(slide_en),
    .frame_start_i(frame_start), .off_o(frame_off), .armed_o(slide_armed)
  );

  assign pattern = ramp_code(BASE, frame_off, pix_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fval_o <= 1'b0;
      lval_o <= 1'b0;
      pval_o <= 1'b0;
      pix_o  <= '0;
    end else begin
      fval_o <= fval_i;
      lval_o <= lval_i;
      pval_o <= pval_i;
      pix_o  <= test_en ? pattern : pix_i;
    end
  end
endmodule

// File: rtl/rpg_checker.sv
module rpg_checker #(
  parameter int RAMP_BASE  = 960,
  parameter int SLIDE_STEP = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode_i,
  input logic        fval_i,
  input logic        lval_i,
  input logic        pval_i,
  input logic [11:0] pix_i,
  input logic        fval_o,
  input logic        lval_o,
  input logic        pval_o,
  input logic [11:0] pix_o,
  input logic        line_start,
  input logic        frame_start,
  input logic [11:0] pix_idx,
  input logic [11:0] frame_off,
  input logic        slide_armed
);
  logic test_m, slide_m;
  assign test_m  = (mode_i == 2'b01) || (mode_i == 2'b10);
  assign slide_m = (mode_i == 2'b10);

  p_video_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !test_m |=> pix_o == $past(pix_i));

  p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (test_m && line_start) |=> pix_o == 12'($past(frame_off) + 12'(RAMP_BASE)));

  p_fixed_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && line_start) |=> pix_o == 12'(RAMP_BASE));

  p_slide_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slide_m && frame_start && slide_armed) |-> frame_off == 12'($past(frame_off) + 12'(SLIDE_STEP)));

  p_slide_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slide_m) |-> frame_off == 12'd0);

  p_strobe_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 1'b1 |-> (fval_o == $past(fval_i)) && (lval_o == $past(lval_i)) && (pval_o == $past(pval_i)));

  p_gap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lval_i && !pval_i && !line_start) |=> (line_start || pix_idx == $past(pix_idx)));

  p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lval_i && pval_i) |=> (line_start || pix_idx == 12'($past(pix_idx) + 12'd1)));
endmodule

bind ramp_pattern_gen rpg_checker #(.RAMP_BASE(RAMP_BASE), .SLIDE_STEP(SLIDE_STEP)) u_rpg_checker (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fval_i(fval_i), .lval_i(lval_i),
  .pval_i(pval_i), .pix_i(pix_i), .fval_o(fval_o), .lval_o(lval_o),
  .pval_o(pval_o), .pix_o(pix_o), .line_start(line_start),
  .frame_start(frame_start), .pix_idx(pix_idx), .frame_off(frame_off),
  .slide_armed(slide_armed)
);

// File: tb/test_ramp_pattern_gen.sv
module test_ramp_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        fval_i = 1'b0, lval_i = 1'b0, pval_i = 1'b0;
  logic [11:0] pix_i = '0;
  logic        fval_o, lval_o, pval_o;
  logic [11:0] pix_o;

  always #2.5 clk = ~clk;

  ramp_pattern_gen i_ramp_pattern_gen (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fval_i(fval_i),
    .lval_i(lval_i), .pval_i(pval_i), .pix_i(pix_i), .fval_o(fval_o),
    .lval_o(lval_o), .pval_o(pval_o), .pix_o(pix_o)
  );

  typedef struct {
    logic        fv, lv, pv;
    logic [11:0] pix;
    string       tag;
  } exp_t;

  exp_t   sb_q[$];
  int     n_chk = 0, n_fail = 0;
  string  cur_tag = "R1";
  logic [11:0] last_valid_pix;
  bit     saw_wrap = 0;

  // bench-side model state
  int  m_cnt = 0, m_off = 0;
  bit  m_armed = 0, m_pfv = 0, m_plv = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle, push expected result
  task automatic drive(input logic fv, input logic lv, input logic pv, input logic [11:0] px);
    exp_t e;
    int idx;
    bit frise, lrise, test;
    @(negedge clk);
    fval_i = fv; lval_i = lv; pval_i = pv; pix_i = px;
    frise = fv && !m_pfv;
    lrise = lv && !m_plv;
    test  = (mode_i == 2'b01) || (mode_i == 2'b10);
    if (mode_i != 2'b10) begin
      m_off = 0; m_armed = 0;
    end else if (frise) begin
      if (m_armed) m_off = (m_off + 2) % 4096;
      m_armed = 1;
    end
    idx = lrise ? 0 : m_cnt;
    if (lrise) m_cnt = pv ? 1 : 0;
    else if (lv && pv) m_cnt = (m_cnt + 1) % 4096;
    m_pfv = fv; m_plv = lv;
    e.fv = fv; e.lv = lv; e.pv = pv; e.tag = cur_tag;
    e.pix = test ? 12'((960 + m_off + idx) % 4096) : px;
    sb_q.push_back(e);
  endtask

  // monitor: compare one cycle after each drive
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check({e.tag, " pix"}, pix_o, e.pix);
      check("R6 strobes", {fval_o, lval_o, pval_o}, {e.fv, e.lv, e.pv});
      if (pval_o) begin
        last_valid_pix = pix_o;
        if (pix_o == 12'd0 && e.tag == "R9") saw_wrap = 1;
      end
    end
  end

  task automatic run_line(input int npix, input bit gaps);
    for (int k = 0; k < npix; k++) begin
      drive(1, 1, 1, 12'($urandom));
      if (gaps && (k % 3 == 1)) drive(1, 1, 0, 12'($urandom));
    end
    drive(1, 0, 0, 12'($urandom));
  endtask

  task automatic run_frame(input int nlines, input int npix, input bit gaps);
    drive(1, 0, 0, 12'($urandom));
    for (int l = 0; l < nlines; l++) run_line(npix, gaps);
    drive(0, 0, 0, 12'($urandom));
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 12'd0);
    while (sb_q.size() > 0) @(posedge clk);
    #2;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset pix", pix_o, 0);
    check("R7 reset strobes", {fval_o, lval_o, pval_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R7 first cycle", {fval_o, lval_o, pval_o, pix_o}, 0);

    cur_tag = "R1";
    mode_i = 2'b00; run_frame(2, 6, 0);
    mode_i = 2'b11; run_frame(1, 5, 1);
    flush();

    cur_tag = "R2";
    mode_i = 2'b01; run_frame(1, 1049, 0);
    flush();
    check("R2 last code of full line", last_valid_pix, 2008);

    cur_tag = "R3";
    run_frame(3, 8, 0);
    run_frame(2, 8, 0);

    cur_tag = "R8";
    run_frame(2, 9, 1);
    flush();

    cur_tag = "R4";
    mode_i = 2'b10;
    for (int f = 0; f < 4; f++) run_frame(2, 5, f[0]);
    flush();
    check("R4 fourth frame last code", last_valid_pix, 960 + 6 + 4);

    cur_tag = "R5";
    mode_i = 2'b01; run_frame(1, 4, 0);
    mode_i = 2'b10; run_frame(1, 4, 0);
    flush();
    check("R5 restart after re-entry", last_valid_pix, 960 + 3);

    cur_tag = "R9";
    for (int f = 0; f < 1570; f++) run_frame(1, 4, 0);
    flush();
    check("R9 wrap observed", saw_wrap, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule